// File: doc/BRIEF.md
# Configuration Startup Sequencer

This block brings a programmable device out of configuration once its bitstream is fully loaded. When the length counter reports that the full length count has been reached, a five-stage phase chain starts stepping, one phase per edge of the sequencer clock. Three events are tied to phases of that chain: the DONE indication goes high, the global three-state on the user I/O is released, and the global reset of every internal flip-flop is released. Each event has its own two-bit option field that picks the phase. A fixed number of edges after DONE rises, a sticky "finished" flag is raised, which is the permission for readback and boundary-scan access.

An option bit picks the sequencer clock: either the configuration clock or a clock net supplied by the user logic. The chain moves only on edges of the selected clock. If that clock stops, the sequence stops with it and the outputs keep their current values. User logic can also drive the global reset and the global three-state directly. Each of those inputs first passes through its own enable and invert options and is then ORed into the matching output. A synchronous clear-memory input puts the block back into its pre-startup state.

Top module: `cfg_startup_seq`

## Requirements
- R1: After an asynchronous reset (rst_n low), the outputs are in the pre-startup state: done_o=0, io_hiz_o=1, gbl_rst_o=1, fin_o=0. This assumes the user gate inputs are disabled.
- R2: Counting the first selected-clock edge that samples full_cnt=1 as edge 1, phase Qk (k=0..4) becomes set on edge k+1. Set phases stay set even if full_cnt later drops.
- R3: done_o goes high on edge n+2 and stays high, where n is the value of sel_done (00 picks Q1, 01 picks Q2, 10 picks Q3, 11 picks Q4).
- R4: The I/O release takes effect on edge m+2, where m is the value of sel_io (same encoding as R3). From then on io_hiz_o equals the effective user three-state; before it, io_hiz_o=1.
- R5: The reset release takes effect on edge r+2, where r is the value of sel_rst (same encoding as R3). From then on gbl_rst_o equals the effective user reset; before it, gbl_rst_o=1. With sel_done=00 and sel_rst=10, reset is released two edges after DONE rises.
- R6: fin_o rises on the third selected-clock edge after the edge on which done_o rose. It then stays high until clear or reset, and it is never high while done_o is low.
- R7: With clk_sel=0 the chain advances only on cfg_clk. With clk_sel=1 it advances only on usr_clk. Edges on the clock that is not selected change no output.
- R8: The effective user reset is ugr_en & (ugr_in ^ ugr_inv). It is ORed into gbl_rst_o combinationally, so with ugr_en=0 the input has no effect.
- R9: The effective user three-state is ugts_en & (ugts_in ^ ugts_inv). It is ORed into io_hiz_o combinationally, so with ugts_en=0 the input has no effect.
- R10: A selected-clock edge with clr_mem=1 clears every phase and the finished flag, which gives the R1 output state. On that edge clr_mem wins over full_cnt=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cfg_clk | input | 1 | Configuration clock |
| usr_clk | input | 1 | User-supplied clock net |
| clk_sel | input | 1 | Sequencer clock select: 0 = cfg_clk, 1 = usr_clk |
| rst_n | input | 1 | Asynchronous power-up reset, active low |
| clr_mem | input | 1 | Synchronous clear-memory / reconfigure request |
| full_cnt | input | 1 | Full length count reached |
| sel_done | input | 2 | Phase select for DONE |
| sel_io | input | 2 | Phase select for I/O release |
| sel_rst | input | 2 | Phase select for reset release |
| ugr_in | input | 1 | User global reset request |
| ugr_en | input | 1 | Enable option for user global reset |
| ugr_inv | input | 1 | Invert option for user global reset |
| ugts_in | input | 1 | User global three-state request |
| ugts_en | input | 1 | Enable option for user global three-state |
| ugts_inv | input | 1 | Invert option for user global three-state |
| done_o | output | 1 | DONE indication (1 = released) |
| io_hiz_o | output | 1 | Global three-state of user I/O (1 = high-impedance) |
| gbl_rst_o | output | 1 | Global reset of internal flip-flops (1 = held) |
| fin_o | output | 1 | Finished flag enabling readback and boundary scan |

## Verification
All three events come from the same thermometer chain, so a phase bit that is stuck or skipped moves at least one of done_o, io_hiz_o or gbl_rst_o off its expected edge. The bench sweeps all 64 combinations of the three select fields and checks every output after every edge, so such an error shows up within one clock of the expected transition. A wrong finished-delay counter shows up as fin_o rising one edge early or late relative to done_o. A clock select that is crossed over shows up when the unselected clock is pulsed and outputs still move. Errors in the gate logic are visible at once on gbl_rst_o or io_hiz_o, because the user paths are combinational.

// File: rtl/startup_pkg.sv
package startup_pkg;

    // number of phase flops in the startup chain
    localparam int NPHASE_DEF = 5;
    // edges from DONE high to the finished flag
    localparam int FIN_DELAY_DEF = 3;
    // phase select width covers Q1..Q(N-1)
    localparam int SEL_W_DEF = $clog2(NPHASE_DEF - 1);

    typedef enum logic [1:0] {
        EVT_DONE = 2'd0,
        EVT_IO   = 2'd1,
        EVT_RST  = 2'd2
    } evt_e;

    localparam int NEVT = 3;

endpackage

// File: rtl/phase_chain.sv
module phase_chain #(
    parameter int NPHASE = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              start,
    output logic [NPHASE-1:1] phase_o
);

    typedef struct packed {
        logic [NPHASE-1:0] q;
    } chain_t;

    chain_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.q = '0;
        end else begin
            st_d.q[0] = st_q.q[0] | start;
            for (int k = 1; k < NPHASE; k++) begin
                st_d.q[k] = st_q.q[k] | st_q.q[k-1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase_o = st_q.q[NPHASE-1:1];

    generate
        for (genvar g = 1; g < NPHASE; g++) begin : g_chk
            // R2
            phase_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (st_q.q[g] && !clr) |=> st_q.q[g]);
            // R2
            phase_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (!st_q.q[g-1] && !clr) |=> !st_q.q[g]);
        end
    endgenerate

endmodule

// File: rtl/event_tap.sv
module event_tap #(
    parameter int NPHASE = 5,
    parameter int SEL_W  = 2
) (
    input  logic [NPHASE-2:0] phase_i,
    input  logic [SEL_W-1:0]  sel_i,
    output logic              hit_o
);

    always_comb begin
        hit_o = 1'b0;
        for (int i = 0; i < NPHASE - 1; i++) begin
            if (int'(sel_i) == i) begin
                hit_o = phase_i[i];
            end
        end
    end

endmodule

// File: rtl/user_gate.sv
module user_gate (
    input  logic req_i,
    input  logic en_i,
    input  logic inv_i,
    output logic eff_o
);

    always_comb begin
        eff_o = en_i & (req_i ^ inv_i);
    end

endmodule

// File: rtl/finish_timer.sv
module finish_timer #(
    parameter int FIN_DELAY = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic done_i,
    output logic fin_o
);

    localparam int AGE_W = $clog2(FIN_DELAY + 1);
    localparam logic [AGE_W-1:0] AGE_MAX  = AGE_W'(FIN_DELAY);
    localparam logic [AGE_W-1:0] AGE_LAST = AGE_W'(FIN_DELAY - 1);

    typedef struct packed {
        logic [AGE_W-1:0] age;
        logic             fin;
    } tmr_t;

    tmr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d = '0;
        end else if (done_i) begin
            if (st_q.age != AGE_MAX) begin
                st_d.age = st_q.age + 1'b1;
            end
            if (st_q.age == AGE_LAST) begin
                st_d.fin = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fin_o = st_q.fin;

    // R6
    fin_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.fin && !clr) |=> st_q.fin);
    // R6
    fin_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!done_i && !clr && !st_q.fin) |=> !st_q.fin);

endmodule

// File: rtl/cfg_startup_seq.sv
module cfg_startup_seq
    import startup_pkg::*;
#(
    parameter int NPHASE    = NPHASE_DEF,
    parameter int FIN_DELAY = FIN_DELAY_DEF,
    parameter int SEL_W     = $clog2(NPHASE - 1)
) (
    input  logic             cfg_clk,
    input  logic             usr_clk,
    input  logic             clk_sel,
    input  logic             rst_n,
    input  logic             clr_mem,
    input  logic             full_cnt,
    input  logic [SEL_W-1:0] sel_done,
    input  logic [SEL_W-1:0] sel_io,
    input  logic [SEL_W-1:0] sel_rst,
    input  logic             ugr_in,
    input  logic             ugr_en,
    input  logic             ugr_inv,
    input  logic             ugts_in,
    input  logic             ugts_en,
    input  logic             ugts_inv,
    output logic             done_o,
    output logic             io_hiz_o,
    output logic             gbl_rst_o,
    output logic             fin_o
);

    logic                  seq_clk;
    logic [NPHASE-1:1]     phase;
    logic [SEL_W-1:0]      sel_arr [NEVT];
    logic [NEVT-1:0]       evt_hit;
    logic                  ugr_eff;
    logic                  ugts_eff;

    // static option bit picks the sequencer clock
    assign seq_clk = clk_sel ? usr_clk : cfg_clk;

    phase_chain #(.NPHASE(NPHASE)) u_chain (
        .clk     (seq_clk),
        .rst_n   (rst_n),
        .clr     (clr_mem),
        .start   (full_cnt),
        .phase_o (phase)
    );

    assign sel_arr[EVT_DONE] = sel_done;
    assign sel_arr[EVT_IO]   = sel_io;
    assign sel_arr[EVT_RST]  = sel_rst;

    generate
        for (genvar e = 0; e < NEVT; e++) begin : g_evt
            event_tap #(.NPHASE(NPHASE), .SEL_W(SEL_W)) u_tap (
                .phase_i (phase),
                .sel_i   (sel_arr[e]),
                .hit_o   (evt_hit[e])
            );
        end
    endgenerate

    user_gate u_gr_gate (
        .req_i (ugr_in),
        .en_i  (ugr_en),
        .inv_i (ugr_inv),
        .eff_o (ugr_eff)
    );

    user_gate u_gts_gate (
        .req_i (ugts_in),
        .en_i  (ugts_en),
        .inv_i (ugts_inv),
        .eff_o (ugts_eff)
    );

    finish_timer #(.FIN_DELAY(FIN_DELAY)) u_fin (
        .clk    (seq_clk),
        .rst_n  (rst_n),
        .clr    (clr_mem),
        .done_i (evt_hit[EVT_DONE]),
        .fin_o  (fin_o)
    );

    always_comb begin
        done_o    = evt_hit[EVT_DONE];
        io_hiz_o  = ~evt_hit[EVT_IO]  | ugts_eff;
        gbl_rst_o = ~evt_hit[EVT_RST] | ugr_eff;
    end

    // R6
    fin_after_done_chk: assert property (@(posedge seq_clk) disable iff (!rst_n)
        fin_o |-> done_o);
    // R10
    clear_state_chk: assert property (@(posedge seq_clk) disable iff (!rst_n)
        clr_mem |=> (!done_o && !fin_o && !evt_hit[EVT_IO] && !evt_hit[EVT_RST]));
    // R3
    done_sticky_chk: assert property (@(posedge seq_clk) disable iff (!rst_n)
        (done_o && !clr_mem) |=> done_o);
    // R6
    fin_not_with_done_rise_chk: assert property (@(posedge seq_clk) disable iff (!rst_n)
        $rose(done_o) |-> !fin_o);

endmodule

// File: tb/sim_cfg_startup_seq.sv
module sim_cfg_startup_seq;

    logic       cfg_clk = 0, usr_clk = 0, clk_sel = 0, rst_n = 0, clr_mem = 0, full_cnt = 0;
    logic [1:0] sel_done = 0, sel_io = 0, sel_rst = 0;
    logic       ugr_in = 0, ugr_en = 0, ugr_inv = 0, ugts_in = 0, ugts_en = 0, ugts_inv = 0;
    logic       done_o, io_hiz_o, gbl_rst_o, fin_o;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    cfg_startup_seq u0 (
        .cfg_clk(cfg_clk), .usr_clk(usr_clk), .clk_sel(clk_sel), .rst_n(rst_n),
        .clr_mem(clr_mem), .full_cnt(full_cnt),
        .sel_done(sel_done), .sel_io(sel_io), .sel_rst(sel_rst),
        .ugr_in(ugr_in), .ugr_en(ugr_en), .ugr_inv(ugr_inv),
        .ugts_in(ugts_in), .ugts_en(ugts_en), .ugts_inv(ugts_inv),
        .done_o(done_o), .io_hiz_o(io_hiz_o), .gbl_rst_o(gbl_rst_o), .fin_o(fin_o)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    // 50 MHz: 20 ns period, sample 5 ns after falling edge
    task automatic pulse_cfg();
        #5 cfg_clk = 1;
        #10 cfg_clk = 0;
        #5;
    endtask

    task automatic pulse_usr();
        #5 usr_clk = 1;
        #10 usr_clk = 0;
        #5;
    endtask

    task automatic pulse_sel();
        if (clk_sel) pulse_usr(); else pulse_cfg();
    endtask

    task automatic do_clear();
        clr_mem = 1;
        pulse_sel();
        clr_mem = 0;
    endtask

    task automatic chk_idle(input string req);
        chk({req, " done"}, done_o, 1'b0);
        chk({req, " hiz"}, io_hiz_o, 1'b1);
        chk({req, " rst"}, gbl_rst_o, 1'b1);
        chk({req, " fin"}, fin_o, 1'b0);
    endtask

    initial begin
        #1_000_000;
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #7 rst_n = 0;
        #20 rst_n = 1;
        #3;
        // R1 reset state
        chk_idle("R1");

        // R2..R6 exhaustive sweep over the three select fields
        for (int c = 0; c < 64; c++) begin
            sel_done = c[1:0];
            sel_io   = c[3:2];
            sel_rst  = c[5:4];
            do_clear();
            chk_idle("R10");
            full_cnt = 1;
            for (int k = 1; k <= 9; k++) begin
                pulse_cfg();
                full_cnt = 0; // R2 chain must keep going after full_cnt drops
                chk("R3", done_o, 1'(k >= int'(sel_done) + 2));
                chk("R4", io_hiz_o, 1'(k < int'(sel_io) + 2));
                chk("R5", gbl_rst_o, 1'(k < int'(sel_rst) + 2));
                chk("R6", fin_o, 1'(k >= int'(sel_done) + 5));
            end
        end

        // R8/R9 gating, before and after release
        sel_done = 0; sel_io = 1; sel_rst = 2;
        for (int ph = 0; ph < 2; ph++) begin
            do_clear();
            if (ph == 1) begin
                full_cnt = 1;
                for (int k = 0; k < 6; k++) pulse_cfg();
                full_cnt = 0;
            end
            for (int g = 0; g < 8; g++) begin
                ugr_in = g[0]; ugr_inv = g[1]; ugr_en = g[2];
                ugts_in = ~g[0]; ugts_inv = g[1]; ugts_en = g[2];
                #1;
                chk("R8", gbl_rst_o, (ph == 0) | (g[2] & (g[0] ^ g[1])));
                chk("R9", io_hiz_o, (ph == 0) | (g[2] & (~g[0] ^ g[1])));
            end
            ugr_en = 0; ugts_en = 0; ugr_in = 0; ugts_in = 0; ugr_inv = 0; ugts_inv = 0;
            #1;
        end

        // R7 clock select: usr_clk selected, cfg_clk edges ignored
        clk_sel = 1;
        do_clear();
        full_cnt = 1;
        for (int k = 0; k < 8; k++) pulse_cfg();
        chk_idle("R7");
        pulse_usr();
        full_cnt = 0;
        chk("R7 stall", done_o, 1'b0);
        pulse_usr();
        chk("R7 usr", done_o, 1'b1);
        // R7 back to cfg_clk: usr_clk edges ignored
        clk_sel = 0;
        do_clear();
        full_cnt = 1;
        for (int k = 0; k < 8; k++) pulse_usr();
        chk_idle("R7 cfg");

        // R10 clear wins over full_cnt, and clears a finished sequence
        for (int k = 0; k < 8; k++) pulse_cfg();
        chk("R10 pre fin", fin_o, 1'b1);
        clr_mem = 1;
        pulse_cfg();
        clr_mem = 0;
        full_cnt = 0;
        chk_idle("R10 clr");
        for (int k = 0; k < 8; k++) pulse_cfg();
        chk_idle("R10 prio");

        // R1 asynchronous reset mid-sequence
        full_cnt = 1;
        for (int k = 0; k < 8; k++) pulse_cfg();
        full_cnt = 0;
        rst_n = 0;
        #2;
        chk_idle("R1 async");
        rst_n = 1;
        #3;

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule